// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the target end of a three-wire serial link made of a chip-enable, a shift clock and one data line that both sides drive in turn. The data line is split into an input, an output and an output enable so that the pad can be placed outside the block. Through this link an external controller reaches a file of sixteen 4-bit registers. All three link inputs are resynchronised to the block's system clock, and edges of the shift clock are detected there. Every action is therefore a registered event in one clock domain.

The controller sends 8-bit command frames, most significant bit first. Each frame can load the address register, write a nibble to the addressed entry, or start a read. A read frame is followed by a fixed eight-clock turnaround phase. In that phase the block takes over the data line, shifts out the addressed nibble and then hands the line back. More frames can follow as long as chip-enable stays high. A parallel host port lets the surrounding logic preload and inspect the register file.

Top module: `serial3_regfile_slave`

## Requirements
- R1: The data line is sampled on each rising shift-clock edge. A frame is 8 bits, MSB first. Bit 7 is ignored, bit 6 is R/W, bit 5 is AD, bit 4 is DT and bits 3..0 are the payload. The frame is decoded on its eighth rising edge.
- R2: When AD=1 and DT=0, the payload is loaded into the address register. Any other AD/DT pair leaves the address register unchanged.
- R3: When DT=1, R/W=0 and AD=0, the payload is written to the entry selected by the address register. No other combination writes the file.
- R4: A frame with R/W=1, AD=1 and DT=0 starts a read of the entry given by its payload. During the next eight shift clocks, the output enable rises at the falling edge of clock 2. D3, D2, D1 and D0 are driven at the falling edges of clocks 5, 6, 7 and 8 in that order.
- R5: The output enable drops at the falling edge of the first clock after the read phase. That clock's rising edge is already bit 7 of a new frame, and a write frame may follow directly.
- R6: The output enable stays low throughout command frames that do not follow a read.
- R7: Chip-enable low clears the bit position, the read phase and the output enable. The next frame after chip-enable rises again is decoded from its first bit.
- R8: The register file resets to zero. A host write lands on the next system clock edge. The host read data always shows the entry selected by the host address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Link chip-enable, active high |
| sclk | input | 1 | Link shift clock |
| sio_in | input | 1 | Data line as seen by the block |
| sio_out | output | 1 | Data bit driven onto the line |
| sio_oe | output | 1 | Drive enable for the data line |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host entry select |
| host_wdata | input | 4 | Host write data |
| host_rdata | output | 4 | Entry contents at host_addr |

## Verification
On every cycle, the assertions check how the line driver is sequenced. The enable may rise only after a falling shift edge, and may fall only at a falling edge or when chip-enable is lost. The driven bit holds between falling edges, and the enable is never high in the body of a command frame. They also check that chip-enable low clears the frame state, that the address register moves only on a rising edge, and that a write and a read start never come from one frame. Whether the right nibble reaches the right entry, whether the bits come out in order on the right clocks, and how the AD/DT/R/W combinations behave can only be shown by the bench's frame sequences.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic {PH_CMD = 1'b0, PH_READ = 1'b1} tws_phase_e;

   typedef struct packed {
      logic rw;
      logic ad;
      logic dt;
   } tws_ctrl_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("tws_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [ADDR_W-1:0] s_raddr,
   output logic [DATA_W-1:0] s_rdata,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (h_we)   mem[h_addr] <= h_wdata;
         if (s_we)   mem[s_addr] <= s_wdata;
      end
   end

   assign s_rdata = mem[s_raddr];
   assign h_rdata = mem[h_addr];
endmodule

// File: rtl/tws_frame.sv
module tws_frame
   import tws_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4,
   parameter int CTRL_W = 4,
   localparam int FRAME_LEN = CTRL_W + ADDR_W,
   localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              rise,
   input  logic              fall,
   input  logic              din,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sio_out,
   output logic              sio_oe,
   output logic [ADDR_W-1:0] addr_q,
   output tws_phase_e        phase,
   output logic [CNT_W-1:0]  cnt,
   output logic              rd_start,
   output logic              addr_load
);
   localparam int NIB_IW = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] PHASE_END  = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] OE_AT      = CNT_W'(2);
   localparam logic [CNT_W-1:0] DOUT_FIRST = CNT_W'(FRAME_LEN - DATA_W + 1);

   if (CTRL_W != 4) begin : g_bad_ctrl
      $error("tws_frame: CTRL_W must be 4");
   end
   if (DATA_W > ADDR_W || DATA_W < 2) begin : g_bad_data
      $error("tws_frame: DATA_W must be in 2..ADDR_W");
   end

   logic [FRAME_LEN-2:0] shift_q;
   logic [FRAME_LEN-1:0] frame_w;
   tws_ctrl_t            ctrl;
   logic [ADDR_W-1:0]    payload;
   logic                 frame_done;
   logic                 release_q;
   logic [DATA_W-1:0]    nib_q;
   logic [NIB_IW-1:0]    dsel;

   assign frame_w    = {shift_q, din};
   assign ctrl       = frame_w[FRAME_LEN-2 -: 3];
   assign payload    = frame_w[ADDR_W-1:0];
   assign frame_done = ce && rise && (phase == PH_CMD) && (cnt == LAST_BIT);
   assign addr_load  = frame_done && ctrl.ad && !ctrl.dt;
   assign wr_en      = frame_done && ctrl.dt && !ctrl.rw && !ctrl.ad;
   assign rd_start   = frame_done && ctrl.rw && ctrl.ad && !ctrl.dt;
   assign rd_addr    = payload;
   assign wr_addr    = addr_q;
   assign wr_data    = payload[DATA_W-1:0];
   assign dsel       = NIB_IW'(PHASE_END - cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q   <= '0;
         cnt       <= '0;
         phase     <= PH_CMD;
         addr_q    <= '0;
         nib_q     <= '0;
         sio_oe    <= 1'b0;
         sio_out   <= 1'b0;
         release_q <= 1'b0;
      end else if (!ce) begin
         cnt       <= '0;
         phase     <= PH_CMD;
         sio_oe    <= 1'b0;
         sio_out   <= 1'b0;
         release_q <= 1'b0;
      end else begin
         if (rise) begin
            shift_q <= frame_w[FRAME_LEN-2:0];
            if (phase == PH_CMD) begin
               if (cnt == LAST_BIT) begin
                  cnt <= '0;
                  if (rd_start) phase <= PH_READ;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else if (cnt == PHASE_END) begin
               phase     <= PH_CMD;
               cnt       <= CNT_W'(1);
               release_q <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (addr_load) addr_q <= payload;
         if (rd_start)  nib_q  <= rd_data;
         if (fall) begin
            if (release_q) begin
               sio_oe    <= 1'b0;
               release_q <= 1'b0;
            end else if (phase == PH_READ) begin
               if (cnt == OE_AT) sio_oe <= 1'b1;
               if (cnt >= DOUT_FIRST) sio_out <= nib_q[dsel];
            end
         end
      end
   end
endmodule

// File: rtl/serial3_regfile_slave.sv
module serial3_regfile_slave
   import tws_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 4,
   parameter int CTRL_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              sclk,
   input  logic              sio_in,
   output logic              sio_out,
   output logic              sio_oe,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);
   localparam int FRAME_LEN = CTRL_W + ADDR_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);

   logic              ce_s, sclk_s, din_s, sclk_d;
   logic              sclk_rise, sclk_fall;
   logic [ADDR_W-1:0] rd_addr, wr_addr, addr_q;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en, rd_start, addr_load;
   tws_phase_e        phase;
   logic [CNT_W-1:0]  cnt;

   tws_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce, sclk, sio_in}),
      .q     ({ce_s, sclk_s, din_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   tws_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce        (ce_s),
      .rise      (sclk_rise),
      .fall      (sclk_fall),
      .din       (din_s),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .sio_out   (sio_out),
      .sio_oe    (sio_oe),
      .addr_q    (addr_q),
      .phase     (phase),
      .cnt       (cnt),
      .rd_start  (rd_start),
      .addr_load (addr_load)
   );

   tws_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_we    (wr_en),
      .s_addr  (wr_addr),
      .s_wdata (wr_data),
      .s_raddr (rd_addr),
      .s_rdata (rd_data),
      .h_we    (host_we),
      .h_addr  (host_addr),
      .h_wdata (host_wdata),
      .h_rdata (host_rdata)
   );
endmodule

// File: rtl/tws_checker.sv
module tws_checker
   import tws_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int FRAME_LEN = 8,
   parameter int CNT_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              rise,
   input logic              fall,
   input logic              sio_oe,
   input logic              sio_out,
   input tws_phase_e        phase,
   input logic [CNT_W-1:0]  cnt,
   input logic [ADDR_W-1:0] addr_q,
   input logic              wr_en,
   input logic              rd_start
);
   p_ce_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> (!sio_oe && cnt == '0 && phase == PH_CMD));

   p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sio_oe) |-> $past(fall));

   p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sio_oe) |-> ($past(fall) || !$past(ce_s)));

   p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sio_oe && $past(sio_oe) && !$past(fall)) |-> $stable(sio_out));

   p_addr_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> $past(rise));

   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_LEN));

   p_decode_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_start}));

   p_no_drive_in_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD && cnt >= CNT_W'(2)) |-> !sio_oe);
endmodule

bind serial3_regfile_slave tws_checker #(
   .ADDR_W    (ADDR_W),
   .FRAME_LEN (FRAME_LEN),
   .CNT_W     (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_s     (ce_s),
   .rise     (sclk_rise),
   .fall     (sclk_fall),
   .sio_oe   (sio_oe),
   .sio_out  (sio_out),
   .phase    (phase),
   .cnt      (cnt),
   .addr_q   (addr_q),
   .wr_en    (wr_en),
   .rd_start (rd_start)
);

// File: tb/serial3_regfile_slave_test.sv
module serial3_regfile_slave_test;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b0, sclk = 1'b0, sio_in = 1'b0;
   logic       sio_out, sio_oe;
   logic       host_we = 1'b0;
   logic [3:0] host_addr = '0, host_wdata = '0;
   logic [3:0] host_rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic so [1:8];
   logic se [1:8];
   logic ro [1:8];
   logic re [1:8];

   always #4 clk = ~clk;

   serial3_regfile_slave uut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sio_in(sio_in),
      .sio_out(sio_out), .sio_oe(sio_oe), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   // {serial_write, addr[3:0], data[3:0]}
   localparam logic [8:0] VEC [8] = '{
      {1'b0, 4'h0, 4'h5}, {1'b1, 4'h1, 4'hA}, {1'b0, 4'hF, 4'hC},
      {1'b1, 4'h7, 4'h3}, {1'b1, 4'h8, 4'hF}, {1'b0, 4'h4, 4'h9},
      {1'b1, 4'hE, 4'h6}, {1'b0, 4'hB, 4'h1}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic b, output logic o, output logic e);
      sio_in = b;
      repeat (HALF) @(negedge clk);
      o = sio_out;
      e = sio_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] f);
      for (int i = 1; i <= 8; i++) pulse(f[8-i], so[i], se[i]);
   endtask

   task automatic ce_up();
      ce = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic ce_down();
      ce = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   function automatic logic [7:0] f_addr(input logic ign, input logic [3:0] a);
      return {ign, 3'b010, a};
   endfunction
   function automatic logic [7:0] f_write(input logic ign, input logic [3:0] d);
      return {ign, 3'b001, d};
   endfunction
   function automatic logic [7:0] f_read(input logic ign, input logic [3:0] a);
      return {ign, 3'b110, a};
   endfunction

   // read frame, 8-clock read phase, then the follow-up frame
   task automatic read_nib(input logic ign, input logic [3:0] a, input logic [7:0] follow,
                           output logic [3:0] d);
      send_frame(f_read(ign, a));
      for (int i = 1; i <= 8; i++) pulse(1'b1, ro[i], re[i]);
      send_frame(follow);
      d = {ro[6], ro[7], ro[8], so[1]};
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] d;
      logic       any_oe;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 reset state
      host_addr = 4'h5;
      #1 chk("R8 reset entry zero", 8'(host_rdata), 8'h0);
      chk("R6 oe low after reset", 8'(sio_oe), 8'h0);

      ce_up();
      // table walk: R1 (ignored bit alternates), R3, R4, R8
      for (int v = 0; v < 8; v++) begin
         logic ign;
         ign = v[0];
         if (VEC[v][8]) begin
            send_frame(f_addr(ign, VEC[v][7:4]));
            send_frame(f_write(~ign, VEC[v][3:0]));
            repeat (2) @(negedge clk);
            host_addr = VEC[v][7:4];
            #1 chk("R3 serial write lands", 8'(host_rdata), 8'(VEC[v][3:0]));
         end else begin
            @(negedge clk);
            host_we = 1'b1; host_addr = VEC[v][7:4]; host_wdata = VEC[v][3:0];
            @(negedge clk);
            host_we = 1'b0;
            #1 chk("R8 host write", 8'(host_rdata), 8'(VEC[v][3:0]));
         end
         read_nib(ign, VEC[v][7:4], 8'h00, d);
         chk("R4 read nibble", 8'(d), 8'(VEC[v][3:0]));
         chk("R4 oe low at clock 1", 8'(re[2]), 8'h0);
         chk("R4 oe high from clock 2", 8'(re[3]), 8'h1);
         chk("R5 oe held through clock 8", 8'(so[1] === 1'bx ? 1'b0 : se[1]), 8'h1);
         chk("R5 released after next clock", 8'(se[2]), 8'h0);
      end

      // R6: command frames without a preceding read never drive
      any_oe = 1'b0;
      send_frame(f_addr(1'b0, 4'h2));
      for (int i = 1; i <= 8; i++) any_oe |= se[i];
      send_frame(f_write(1'b1, 4'hD));
      for (int i = 1; i <= 8; i++) any_oe |= se[i];
      chk("R6 no drive in command frames", 8'(any_oe), 8'h0);

      // R2: AD=1 DT=1 leaves address; R3: that frame does not write either
      send_frame(f_addr(1'b0, 4'h3));
      send_frame({1'b0, 3'b011, 4'h9});
      send_frame(f_write(1'b0, 4'h6));
      repeat (2) @(negedge clk);
      host_addr = 4'h3;
      #1 chk("R2 address kept on AD=DT=1", 8'(host_rdata), 8'h6);
      host_addr = 4'h9;
      #1 chk("R3 no write on AD=DT=1", 8'(host_rdata), 8'h0);

      // R3: R/W=1 with DT=1 does not write (address still 3)
      send_frame({1'b0, 3'b101, 4'hB});
      repeat (2) @(negedge clk);
      host_addr = 4'h3;
      #1 chk("R3 no write with R/W=1", 8'(host_rdata), 8'h6);

      // R5: read directly followed by a write frame, same chip-enable
      read_nib(1'b1, 4'hC, f_write(1'b1, 4'h4), d);
      chk("R5 read before write", 8'(d), 8'h0);
      repeat (2) @(negedge clk);
      host_addr = 4'hC;
      #1 chk("R5 write after read", 8'(host_rdata), 8'h4);
      ce_down();

      // R7: abort partway through a frame, then a clean frame pair
      ce_up();
      for (int i = 0; i < 5; i++) pulse(1'b1, so[1], se[1]);
      ce_down();
      ce_up();
      send_frame(f_addr(1'b0, 4'hA));
      send_frame(f_write(1'b0, 4'h7));
      repeat (2) @(negedge clk);
      host_addr = 4'hA;
      #1 chk("R7 framing restarts after abort", 8'(host_rdata), 8'h7);

      // R7: chip-enable lost in the middle of a read phase
      send_frame(f_read(1'b0, 4'hA));
      for (int i = 1; i <= 4; i++) pulse(1'b0, ro[i], re[i]);
      chk("R4 oe high before abort", 8'(sio_oe), 8'h1);
      ce_down();
      chk("R7 oe dropped on ce low", 8'(sio_oe), 8'h0);
      ce_up();
      read_nib(1'b0, 4'hA, 8'h00, d);
      chk("R7 read after abort", 8'(d), 8'h7);
      ce_down();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule